// File: doc/BRIEF.md
# Dual-Path Mesh Link Channel

This block carries one direction of a 64-bit flit stream between two neighbouring mesh routers. It has two data paths. When both routers share one supply and clock, flits travel a single registered stage that adds one cycle and needs no synchronisation. When the routers run in separate voltage and clock islands, flits go through a six-entry dual-clock FIFO whose write side is clocked by the sender and whose read side is clocked by the receiver. One mode value drives both the path mux at the sending end and the path demux at the receiving end.

The path is changed with a request and acknowledge pair on the sender's clock. While a change is pending, the block stops taking new flits. It waits until the active path is empty. It then sets the new mode, waits until the receiving end has adopted it, and returns a one-cycle done pulse. The power manager must finish this exchange before it changes either island's supply or clock. While the link is in direct mode, the FIFO pointers are held at their reset position, so the FIFO is always empty when the link next enters FIFO mode.

Top module: `link_channel`

## Requirements
- R1: After reset the link is in direct mode (`link_mode` = 0), `out_valid` = 0, `sw_done` = 0 and `in_ready` = 1.
- R2: In direct mode (`link_mode` = 0), a flit accepted at a clock edge appears unchanged on `out_flit` with `out_valid` = 1 right after that same edge.
- R3: In direct mode, a flit presented with `out_ready` = 0 holds `out_valid` and `out_flit` steady, and `in_ready` stays 0 while the stage is full and `out_ready` is 0.
- R4: Every accepted flit leaves the link exactly once and in acceptance order, in either mode and across mode changes.
- R5: In FIFO mode (`link_mode` = 1), with the reader stalled, the link accepts exactly 6 flits before `in_ready` drops.
- R6: A switch request (`sw_req` = 1, `sw_mode` = target, where 0 is direct and 1 is FIFO) that names a mode other than the current one forces `in_ready` to 0 from the cycle after it is taken until `sw_done`.
- R7: For a real mode change, `sw_done` is not raised while any accepted flit is still inside the link, and `out_valid` is 0 when it is raised.
- R8: A switch request that names the current mode is answered with `sw_done` = 1 in the next cycle, and `sw_done` is a single-cycle pulse.
- R9: When the link re-enters FIFO mode after an earlier FIFO session, `out_valid` stays 0 until a new flit is written.
- R10: `link_mode` changes only while a switch is in progress, and it equals the requested mode when `sw_done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Sender clock |
| wrst_n | input | 1 | Sender-side asynchronous reset, active low |
| rclk | input | 1 | Receiver clock; must equal wclk in direct mode |
| rrst_n | input | 1 | Receiver-side asynchronous reset, active low |
| in_valid | input | 1 | Flit offered by the sending router |
| in_ready | output | 1 | Link can take the offered flit |
| in_flit | input | 64 | Incoming flit |
| out_valid | output | 1 | Flit available to the receiving router |
| out_ready | input | 1 | Receiving router takes the flit |
| out_flit | output | 64 | Outgoing flit |
| sw_req | input | 1 | Path change request, one sender-clock pulse |
| sw_mode | input | 1 | Requested path: 0 direct, 1 FIFO |
| sw_done | output | 1 | One-cycle acknowledge that the requested path is active |
| link_mode | output | 1 | Path currently selected on the sender side |

## Verification
The bench requests a change back to direct mode while three flits are still held in a stalled FIFO. A design that acknowledged the request before draining would raise `sw_done` early and would drop or reorder those flits. It also re-enters FIFO mode after the read pointer has moved away from slot zero. If the pointers were not parked during direct mode, old entries would appear as valid at that point. The full test stalls the reader and counts accepted flits, so an off-by-one in the token-ring full compare shows up as 5 or 7 accepted flits. In direct mode the bench checks the one-cycle latency and the hold of a stalled flit, which catch a dropped register or a stage that overwrites its data.

// File: rtl/link_pkg.sv
`timescale 1ns/1ps
package link_pkg;
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_FIFO   = 1'b1
    } link_mode_e;

    typedef enum logic [1:0] {
        SW_IDLE    = 2'd0,
        SW_DRAIN   = 2'd1,
        SW_HANDOFF = 2'd2
    } sw_state_e;
endpackage

// File: rtl/link_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser; each bit is treated as independent by its users.
module link_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/link_bisync_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with one-hot token-ring pointers of 2*DEPTH positions.
// Empty and full each depend on a single synchronised token bit.
module link_bisync_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 6
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         w_hold,
    input  logic         w_en,
    input  logic [W-1:0] w_data,
    output logic         w_full,
    output logic         w_empty,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         r_hold,
    input  logic         r_en,
    output logic         r_valid,
    output logic [W-1:0] r_data
);
    localparam int              RING     = 2 * DEPTH;
    localparam logic [RING-1:0] TOK_INIT = {{(RING-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [RING-1:0] tok;
    } ptr_t;

    ptr_t wr_d, wr_q, rd_d, rd_q;
    logic [RING-1:0]  rtok_w;   // reader token seen in wclk domain
    logic [RING-1:0]  wtok_r;   // writer token seen in rclk domain
    logic [DEPTH-1:0] wsel, rsel;
    logic             wr_fire, rd_fire;
    logic [W-1:0]     mem [DEPTH];

    link_sync2 #(.W(RING), .RST_VAL(TOK_INIT)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rd_q.tok), .q(rtok_w)
    );
    link_sync2 #(.W(RING), .RST_VAL(TOK_INIT)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wr_q.tok), .q(wtok_r)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            assign wsel[i] = wr_q.tok[i] | wr_q.tok[i+DEPTH];
            assign rsel[i] = rd_q.tok[i] | rd_q.tok[i+DEPTH];
        end
    endgenerate

    // ---------------- write side ----------------
    assign w_full  = |(rtok_w & {wr_q.tok[DEPTH-1:0], wr_q.tok[RING-1:DEPTH]});
    assign w_empty = |(rtok_w & wr_q.tok);
    assign wr_fire = w_en && !w_full && !w_hold;

    always_comb begin
        wr_d = wr_q;
        if (w_hold) begin
            wr_d.tok = TOK_INIT;
        end else if (wr_fire) begin
            wr_d.tok = {wr_q.tok[RING-2:0], wr_q.tok[RING-1]};
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wr_q.tok <= TOK_INIT;
        end else begin
            wr_q <= wr_d;
        end
    end

    always_ff @(posedge wclk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_fire && wsel[i]) begin
                mem[i] <= w_data;
            end
        end
    end

    // ---------------- read side ----------------
    assign r_valid = !(|(wtok_r & rd_q.tok)) && !r_hold;
    assign rd_fire = r_en && r_valid;

    always_comb begin
        r_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            r_data = r_data | (rsel[i] ? mem[i] : '0);
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (r_hold) begin
            rd_d.tok = TOK_INIT;
        end else if (rd_fire) begin
            rd_d.tok = {rd_q.tok[RING-2:0], rd_q.tok[RING-1]};
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rd_q.tok <= TOK_INIT;
        end else begin
            rd_q <= rd_d;
        end
    end
endmodule

// File: rtl/link_direct_stage.sv
`timescale 1ns/1ps
// Single registered wire stage used when both ends share a clock.
module link_direct_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] take_data,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.data  = take_data;
        end else if (pop) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;
endmodule

// File: rtl/link_mode_ctrl.sv
`timescale 1ns/1ps
// Sender-side path change sequencer: drain, flip, wait for receiver, ack.
module link_mode_ctrl
    import link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic       sw_mode,
    input  logic       drained,
    input  logic       peer_mode,
    output link_mode_e mode,
    output logic       busy,
    output logic       done
);
    typedef struct packed {
        sw_state_e  st;
        link_mode_e mode;
        link_mode_e target;
        logic       done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.st)
            SW_IDLE: begin
                if (sw_req) begin
                    if (link_mode_e'(sw_mode) == c_q.mode) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.target = link_mode_e'(sw_mode);
                        c_d.st     = SW_DRAIN;
                    end
                end
            end
            SW_DRAIN: begin
                if (drained) begin
                    c_d.mode = c_q.target;
                    c_d.st   = SW_HANDOFF;
                end
            end
            SW_HANDOFF: begin
                if (link_mode_e'(peer_mode) == c_q.mode) begin
                    c_d.st   = SW_IDLE;
                    c_d.done = 1'b1;
                end
            end
            default: c_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= SW_IDLE;
            c_q.mode   <= MODE_DIRECT;
            c_q.target <= MODE_DIRECT;
            c_q.done   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mode = c_q.mode;
    assign busy = (c_q.st != SW_IDLE);
    assign done = c_q.done;
endmodule

// File: rtl/link_channel.sv
`timescale 1ns/1ps
module link_channel
    import link_pkg::*;
#(
    parameter int FLIT_W     = 64,
    parameter int FIFO_DEPTH = 6
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLIT_W-1:0] out_flit,
    input  logic              sw_req,
    input  logic              sw_mode,
    output logic              sw_done,
    output logic              link_mode
);
    link_mode_e        mode_w;
    logic              ctrl_busy;
    logic              rmode;      // path select seen by the receiver
    logic              peer_mode;  // receiver's select echoed to sender
    logic              dir_valid;
    logic [FLIT_W-1:0] dir_data;
    logic              fifo_full, fifo_empty_w, fifo_valid;
    logic [FLIT_W-1:0] fifo_data;
    logic              use_fifo_w, use_fifo_r, accept;

    link_mode_ctrl u_ctrl (
        .clk(wclk), .rst_n(wrst_n), .sw_req(sw_req), .sw_mode(sw_mode),
        .drained(!dir_valid && fifo_empty_w), .peer_mode(peer_mode),
        .mode(mode_w), .busy(ctrl_busy), .done(sw_done)
    );

    link_sync2 #(.W(1), .RST_VAL(1'b0)) u_mode_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(mode_w == MODE_FIFO), .q(rmode)
    );
    link_sync2 #(.W(1), .RST_VAL(1'b0)) u_mode_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rmode), .q(peer_mode)
    );

    assign use_fifo_w = (mode_w == MODE_FIFO);
    assign use_fifo_r = rmode;

    // sender-side mux
    always_comb begin
        if (ctrl_busy) begin
            in_ready = 1'b0;
        end else if (use_fifo_w) begin
            in_ready = !fifo_full;
        end else begin
            in_ready = !dir_valid || out_ready;
        end
    end
    assign accept = in_valid && in_ready;

    link_direct_stage #(.W(FLIT_W)) u_direct (
        .clk(wclk), .rst_n(wrst_n),
        .take(accept && !use_fifo_w), .take_data(in_flit),
        .pop(out_ready && !use_fifo_r),
        .valid(dir_valid), .data(dir_data)
    );

    link_bisync_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .wclk(wclk), .wrst_n(wrst_n),
        .w_hold(!use_fifo_w && !peer_mode),
        .w_en(accept && use_fifo_w), .w_data(in_flit),
        .w_full(fifo_full), .w_empty(fifo_empty_w),
        .rclk(rclk), .rrst_n(rrst_n),
        .r_hold(!use_fifo_r),
        .r_en(out_ready && use_fifo_r),
        .r_valid(fifo_valid), .r_data(fifo_data)
    );

    // receiver-side demux
    assign out_valid = use_fifo_r ? fifo_valid : dir_valid;
    assign out_flit  = use_fifo_r ? fifo_data  : dir_data;
    assign link_mode = use_fifo_w;
endmodule

// File: rtl/link_channel_chk.sv
`timescale 1ns/1ps
module link_channel_chk #(
    parameter int FLIT_W = 64
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              sw_req,
    input logic              sw_mode,
    input logic              sw_done,
    input logic              link_mode,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FLIT_W-1:0] out_flit,
    input logic              busy,
    input logic              dir_valid
);
    // R6
    switch_blocks_input_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (sw_req && !busy && sw_mode != link_mode) |=> !in_ready);

    // R8
    same_mode_ack_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (sw_req && !busy && sw_mode == link_mode) |=> sw_done);

    // R7
    done_after_drain_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (sw_done && $past(busy)) |-> (!dir_valid && !out_valid));

    // R10
    mode_steady_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!busy && !sw_req) |=> $stable(link_mode));

    // R3
    direct_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!link_mode && !busy && out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
endmodule

bind link_channel link_channel_chk #(.FLIT_W(FLIT_W)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .sw_req(sw_req), .sw_mode(sw_mode),
    .sw_done(sw_done), .link_mode(link_mode), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .busy(ctrl_busy), .dir_valid(dir_valid)
);

// File: tb/sim_link_channel.sv
`timescale 1ns/1ps
module sim_link_channel;
    logic        wclk = 1'b0;
    logic        aclk = 1'b0;
    logic        same_clk = 1'b1;
    logic        rclk;
    logic        wrst_n = 1'b0, rrst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [63:0] in_flit = '0;
    logic        out_valid, out_ready;
    logic [63:0] out_flit;
    logic        sw_req = 1'b0, sw_mode = 1'b0, sw_done, link_mode;

    always #4 wclk = ~wclk;          // 125 MHz
    always #6.5 aclk = ~aclk;        // unrelated receiver clock
    assign rclk = same_clk ? wclk : aclk;

    link_channel u0 (
        .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .sw_req(sw_req), .sw_mode(sw_mode), .sw_done(sw_done), .link_mode(link_mode)
    );

    int n_chk = 0, n_bad = 0;
    int seq = 0;
    logic [63:0] tx_data [512];
    logic [63:0] rx_data [512];
    int tx_n = 0, rx_n = 0;
    int rdy_mode = 0;   // 0 always, 1 never, 2 three of four
    int rdy_cnt  = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_val();
        logic [63:0] v;
        v = 64'hA5A5_0000_0000_0000 | (64'(seq) * 64'h0001_0003);
        seq++;
        return v;
    endfunction

    // receiver: set ready on rclk falling edge, record handshakes before the rise
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge rclk);
            rdy_cnt++;
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = 1'b0;
                default: out_ready = (rdy_cnt % 4) != 0;
            endcase
            #1;
            if (out_valid && out_ready && rx_n < 512) begin
                rx_data[rx_n] = out_flit;
                rx_n++;
            end
        end
    end

    task automatic send_burst(input int n);
        logic [63:0] v;
        @(negedge wclk);
        for (int k = 0; k < n; k++) begin
            v = next_val();
            in_valid = 1'b1;
            in_flit  = v;
            #1;
            while (!in_ready) begin
                @(negedge wclk);
                #1;
            end
            tx_data[tx_n] = v;
            tx_n++;
            @(negedge wclk);
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_rx(input string req);
        int first_bad;
        for (int k = 0; k < 3000 && rx_n != tx_n; k++) @(negedge wclk);
        chk(rx_n == tx_n, req, 64'(rx_n), 64'(tx_n));
        first_bad = -1;
        for (int k = 0; k < tx_n && k < rx_n; k++)
            if (first_bad < 0 && rx_data[k] !== tx_data[k]) first_bad = k;
        if (first_bad >= 0) chk(1'b0, req, rx_data[first_bad], tx_data[first_bad]);
        else chk(1'b1, req, 64'd0, 64'd0);
    endtask

    task automatic request_switch(input logic m, output int lat);
        @(negedge wclk);
        sw_mode = m;
        sw_req  = 1'b1;
        @(negedge wclk);
        sw_req  = 1'b0;
        lat = 0;
        while (!sw_done && lat < 200) begin
            @(negedge wclk);
            lat++;
        end
    endtask

    task automatic t_reset();
        #2;
        chk(link_mode == 1'b0, "R1 mode", 64'(link_mode), 64'd0);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(sw_done == 1'b0, "R1 sw_done", 64'(sw_done), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_noop_switch();
        @(negedge wclk);
        sw_mode = 1'b0;
        sw_req  = 1'b1;
        @(negedge wclk);
        sw_req  = 1'b0;
        #1;
        chk(sw_done == 1'b1, "R8 same-mode ack", 64'(sw_done), 64'd1);
        @(negedge wclk);
        #1;
        chk(sw_done == 1'b0, "R8 pulse width", 64'(sw_done), 64'd0);
    endtask

    task automatic t_direct_latency();
        logic [63:0] v;
        rdy_mode = 0;
        @(negedge wclk);
        v = next_val();
        in_valid = 1'b1;
        in_flit  = v;
        #1;
        chk(in_ready == 1'b1, "R2 ready", 64'(in_ready), 64'd1);
        tx_data[tx_n] = v;
        tx_n++;
        @(negedge wclk);
        in_valid = 1'b0;
        #2;
        chk(out_valid == 1'b1, "R2 valid after one edge", 64'(out_valid), 64'd1);
        chk(out_flit == v, "R2 data", out_flit, v);
        wait_rx("R2 delivery");
    endtask

    task automatic t_direct_hold();
        logic [63:0] a;
        rdy_mode = 1;
        repeat (2) @(negedge wclk);
        a = tx_n > 0 ? 64'd0 : 64'd0;
        send_burst(1);
        a = tx_data[tx_n-1];
        @(negedge wclk);
        in_valid = 1'b1;
        in_flit  = 64'hDEAD_BEEF_0000_0001;
        #2;
        chk(in_ready == 1'b0, "R3 ready low when stage full", 64'(in_ready), 64'd0);
        repeat (3) @(negedge wclk);
        in_valid = 1'b0;
        #2;
        chk(out_valid == 1'b1, "R3 valid held", 64'(out_valid), 64'd1);
        chk(out_flit == a, "R3 data held", out_flit, a);
        rdy_mode = 2;
        send_burst(24);
        wait_rx("R3 direct stream order");
    endtask

    task automatic t_to_fifo();
        int lat;
        rdy_mode = 0;
        @(negedge wclk);
        sw_mode = 1'b1;
        sw_req  = 1'b1;
        @(negedge wclk);
        sw_req  = 1'b0;
        in_valid = 1'b1;
        in_flit  = 64'hBAD0_0000_0000_0002;
        #1;
        chk(in_ready == 1'b0, "R6 input blocked", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        lat = 0;
        while (!sw_done && lat < 200) begin
            @(negedge wclk);
            lat++;
        end
        chk(lat < 200, "R10 switch completes", 64'(lat), 64'd0);
        chk(link_mode == 1'b1, "R10 mode at done", 64'(link_mode), 64'd1);
        chk(out_valid == 1'b0, "R9 no stale after entry", 64'(out_valid), 64'd0);
        rdy_mode = 1;
        repeat (2) @(negedge wclk);
        same_clk = 1'b0;
        repeat (6) @(negedge wclk);
        #1;
        chk(out_valid == 1'b0, "R9 empty after clock change", 64'(out_valid), 64'd0);
    endtask

    task automatic t_fifo_stream();
        rdy_mode = 2;
        send_burst(40);
        wait_rx("R4 fifo stream order");
    endtask

    task automatic t_fifo_full();
        int acc;
        logic [63:0] v;
        rdy_mode = 1;
        repeat (4) @(negedge wclk);
        acc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge wclk);
            v = 64'hA5A5_0000_0000_0000 | (64'(seq) * 64'h0001_0003);
            in_valid = 1'b1;
            in_flit  = v;
            #1;
            if (in_ready) begin
                tx_data[tx_n] = v;
                tx_n++;
                seq++;
                acc++;
            end
        end
        @(negedge wclk);
        in_valid = 1'b0;
        chk(acc == 6, "R5 depth", 64'(acc), 64'd6);
        rdy_mode = 0;
        wait_rx("R4 drain after full");
    endtask

    task automatic t_switch_with_data();
        int quiet;
        rdy_mode = 1;
        repeat (3) @(negedge wclk);
        same_clk = 1'b1;
        repeat (4) @(negedge wclk);
        send_burst(3);
        @(negedge wclk);
        sw_mode = 1'b0;
        sw_req  = 1'b1;
        @(negedge wclk);
        sw_req  = 1'b0;
        quiet = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge wclk);
            #1;
            if (sw_done) quiet++;
        end
        chk(quiet == 0, "R7 no ack while flits inside", 64'(quiet), 64'd0);
        rdy_mode = 0;
        quiet = 0;
        while (!sw_done && quiet < 200) begin
            @(negedge wclk);
            quiet++;
        end
        chk(link_mode == 1'b0, "R10 back to direct", 64'(link_mode), 64'd0);
        wait_rx("R4 no loss across change");
        rdy_mode = 2;
        send_burst(10);
        wait_rx("R2 direct after return");
    endtask

    task automatic t_reenter_fifo();
        int lat;
        rdy_mode = 0;
        request_switch(1'b1, lat);
        chk(lat < 200, "R10 re-entry completes", 64'(lat), 64'd0);
        #1;
        chk(out_valid == 1'b0, "R9 no stale on re-entry", 64'(out_valid), 64'd0);
        repeat (5) @(negedge wclk);
        #1;
        chk(out_valid == 1'b0, "R9 still empty", 64'(out_valid), 64'd0);
        send_burst(8);
        wait_rx("R4 fifo after re-entry");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge wclk);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        @(negedge wclk);
        t_reset();
        t_noop_switch();
        t_direct_latency();
        t_direct_hold();
        t_to_fifo();
        t_fifo_stream();
        t_fifo_full();
        t_switch_with_data();
        t_reenter_fifo();
        repeat (10) @(negedge wclk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule